// File: doc/BRIEF.md
# Display controller command parser

This block sits behind the byte receiver of a serial display link. Every strobe brings one byte together with a select line. A high select level marks the byte as pixel data. A low level marks it as a command byte. In command mode the block takes an opcode and then collects the fixed number of argument bytes that opcode needs. It then either executes the command or drops it, and waits for a fresh opcode. The executed commands load the column window, load the row window, or load the remap control byte. Every other known opcode is parsed for its length only.

In data mode the byte goes to the framebuffer writer. It is tagged with the current column and row pointer. The pointers then step through the programmed window, either along columns or along rows. The window is 64 byte columns by 80 rows, and both sizes are parameters.

Top module: `oled_cmd_parser`

## Requirements
- R1: After reset the column window is 0..63, the row window is 0..79, both pointers are 0 and the remap byte is 0. A horizontal stream of 64*80 data bytes therefore visits every address in row-major order and then returns to (0,0).
- R2: A byte strobed with `dc_sel_i` high appears one cycle later on `pix_data_o`, with `pix_valid_o` high and with the pointer values that applied before the write. A command byte never raises `pix_valid_o`.
- R3: Opcode 0x15 with two arguments (a, b) sets the column pointer and column start to a mod 64, and the column end to b mod 64.
- R4: Opcode 0x75 with two arguments (a, b) sets the row pointer and row start to a mod 80, and the row end to b mod 80.
- R5: Opcode 0xA0 with one argument stores that argument on `remap_o`. Bit 2 of the stored byte selects vertical stepping.
- R6: With remap bit 2 clear, each data write increments the column. When the column passes the column end, it returns to column start and the row increments. A row past the row end returns to row start.
- R7: With remap bit 2 set, each data write increments the row. When the row passes the row end, it returns to row start and the column increments. A column past the column end returns to column start.
- R8: The number of argument bytes consumed is fixed per opcode:
  - one byte for 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF;
  - eight bytes for 0xB8;
  - none for 0x84-0x86, 0xA4-0xA7, 0xAE, 0xAF, 0xE3 and 0xFF.
- R9: Any other opcode completes at once with no arguments, and raises `unknown_cmd_o` for exactly the one cycle after its strobe.
- R10: Data bytes that arrive in the middle of a command leave the partial command pending. The following command bytes continue to fill it.
- R11: The opcodes that are only parsed (those listed in R8) leave the window, the pointers and the remap byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | One-cycle strobe for `byte_i` |
| dc_sel_i | input | 1 | 1 = pixel data, 0 = command byte |
| byte_i | input | 8 | Received byte |
| pix_valid_o | output | 1 | Framebuffer write strobe |
| pix_data_o | output | 8 | Byte to write |
| pix_col_o | output | 6 | Column address of the write |
| pix_row_o | output | 7 | Row address of the write |
| remap_o | output | 8 | Stored remap control byte |
| unknown_cmd_o | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
The hardest behaviour to expose from the ports is the argument count of an opcode that has no visible effect. A wrong count only shows up later, when the parser swallows or misreads the bytes that follow. The bench sweeps all 256 opcodes. Each opcode is given the expected number of filler bytes, and every filler byte is itself an unknown opcode, so any byte misread as an opcode raises the error flag. The bench then loads a column and row window derived from the opcode value and checks the addresses of two data writes. A miscount shifts that setup and moves the addresses. A separate case switches to data mode between the arguments of a window command.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_COL,
    ACT_ROW,
    ACT_REMAP
  } act_e;

  localparam int unsigned MAX_ARGS = 8;
  localparam int unsigned ARG_W    = $clog2(MAX_ARGS + 1);

  typedef struct packed {
    logic             known;
    logic [ARG_W-1:0] nargs;
    act_e             act;
  } op_info_t;

  function automatic op_info_t lookup_op(input logic [7:0] op);
    op_info_t r;
    r.known = 1'b1;
    r.nargs = '0;
    r.act   = ACT_NONE;
    case (op)
      8'h15: begin r.nargs = ARG_W'(2); r.act = ACT_COL;   end
      8'h75: begin r.nargs = ARG_W'(2); r.act = ACT_ROW;   end
      8'hA0: begin r.nargs = ARG_W'(1); r.act = ACT_REMAP; end
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: r.nargs = ARG_W'(1);
      8'hB8: r.nargs = ARG_W'(8);
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, 8'hFF: r.nargs = '0;
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/oled_op_decode.sv
module oled_op_decode
  import oled_cmd_pkg::*;
(
  input  logic [7:0] op_i,
  output op_info_t   info_o
);
  always_comb info_o = lookup_op(op_i);
endmodule

// File: rtl/oled_cmd_seq.sv
module oled_cmd_seq
  import oled_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_stb_i,
  input  logic [7:0] byte_i,
  output act_e       act_o,
  output logic [7:0] first_o,
  output logic [7:0] last_o,
  output logic       unknown_o
);
  logic             pend_q, pend_d;
  logic [7:0]       op_q, op_d, arg0_q, arg0_d;
  logic [ARG_W-1:0] cnt_q, cnt_d;
  logic             done, unk_d;
  logic [7:0]       cur_op;
  op_info_t         info;

  // opcode under decode: held one while arguments arrive, else the new byte
  assign cur_op = pend_q ? op_q : byte_i;

  oled_op_decode u_dec (
    .op_i  (cur_op),
    .info_o(info)
  );

  always_comb begin
    pend_d = pend_q;
    op_d   = op_q;
    arg0_d = arg0_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    unk_d  = 1'b0;
    if (cmd_stb_i) begin
      if (!pend_q) begin
        if (info.nargs == '0) begin
          done  = 1'b1;
          unk_d = !info.known;
        end else begin
          pend_d = 1'b1;
          op_d   = byte_i;
          cnt_d  = '0;
        end
      end else begin
        if (cnt_q == '0) arg0_d = byte_i;
        if (cnt_q + ARG_W'(1) == info.nargs) begin
          done   = 1'b1;
          pend_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + ARG_W'(1);
        end
      end
    end
  end

  assign act_o   = done ? info.act : ACT_NONE;
  assign first_o = (cnt_q == '0) ? byte_i : arg0_q;
  assign last_o  = byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      op_q      <= '0;
      arg0_q    <= '0;
      cnt_q     <= '0;
      unknown_o <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      op_q      <= op_d;
      arg0_q    <= arg0_d;
      cnt_q     <= cnt_d;
      unknown_o <= unk_d;
    end
  end
endmodule

// File: rtl/oled_addr_gen.sv
module oled_addr_gen
  import oled_cmd_pkg::*;
#(
  parameter int unsigned NUM_COLS = 64,
  parameter int unsigned NUM_ROWS = 80,
  parameter int unsigned VERT_BIT = 2,
  localparam int unsigned CW = $clog2(NUM_COLS),
  localparam int unsigned RW = $clog2(NUM_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  act_e          act_i,
  input  logic [7:0]    first_i,
  input  logic [7:0]    last_i,
  input  logic          data_stb_i,
  input  logic [7:0]    byte_i,
  output logic          pix_valid_o,
  output logic [7:0]    pix_data_o,
  output logic [CW-1:0] pix_col_o,
  output logic [RW-1:0] pix_row_o,
  output logic [7:0]    remap_o
);
  logic [CW-1:0] col_q, cs_q, ce_q, col_nx;
  logic [RW-1:0] row_q, rs_q, re_q, row_nx;
  logic [CW:0]   c_inc;
  logic [RW:0]   r_inc;
  logic [CW-1:0] a_col, b_col;
  logic [RW-1:0] a_row, b_row;

  assign a_col = CW'(first_i % 8'(NUM_COLS));
  assign b_col = CW'(last_i  % 8'(NUM_COLS));
  assign a_row = RW'(first_i % 8'(NUM_ROWS));
  assign b_row = RW'(last_i  % 8'(NUM_ROWS));

  // pointer step; compares use one extra bit so passing the end is visible
  always_comb begin
    c_inc = {1'b0, col_q};
    r_inc = {1'b0, row_q};
    if (remap_o[VERT_BIT]) begin
      r_inc = {1'b0, row_q} + 1'b1;
      if (r_inc > {1'b0, re_q}) begin
        r_inc = {1'b0, rs_q};
        c_inc = {1'b0, col_q} + 1'b1;
      end
      if (c_inc > {1'b0, ce_q}) c_inc = {1'b0, cs_q};
    end else begin
      c_inc = {1'b0, col_q} + 1'b1;
      if (c_inc > {1'b0, ce_q}) begin
        c_inc = {1'b0, cs_q};
        r_inc = {1'b0, row_q} + 1'b1;
      end
      if (r_inc > {1'b0, re_q}) r_inc = {1'b0, rs_q};
    end
    col_nx = c_inc[CW-1:0];
    row_nx = r_inc[RW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q       <= '0;
      cs_q        <= '0;
      ce_q        <= CW'(NUM_COLS - 1);
      row_q       <= '0;
      rs_q        <= '0;
      re_q        <= RW'(NUM_ROWS - 1);
      remap_o     <= '0;
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      pix_col_o   <= '0;
      pix_row_o   <= '0;
    end else begin
      pix_valid_o <= data_stb_i;
      if (data_stb_i) begin
        pix_data_o <= byte_i;
        pix_col_o  <= col_q;
        pix_row_o  <= row_q;
        col_q      <= col_nx;
        row_q      <= row_nx;
      end
      case (act_i)
        ACT_COL: begin
          col_q <= a_col;
          cs_q  <= a_col;
          ce_q  <= b_col;
        end
        ACT_ROW: begin
          row_q <= a_row;
          rs_q  <= a_row;
          re_q  <= b_row;
        end
        ACT_REMAP: remap_o <= first_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/oled_cmd_parser.sv
module oled_cmd_parser
  import oled_cmd_pkg::*;
#(
  parameter int unsigned NUM_COLS = 64,
  parameter int unsigned NUM_ROWS = 80,
  parameter int unsigned VERT_BIT = 2,
  localparam int unsigned CW = $clog2(NUM_COLS),
  localparam int unsigned RW = $clog2(NUM_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic          dc_sel_i,
  input  logic [7:0]    byte_i,
  output logic          pix_valid_o,
  output logic [7:0]    pix_data_o,
  output logic [CW-1:0] pix_col_o,
  output logic [RW-1:0] pix_row_o,
  output logic [7:0]    remap_o,
  output logic          unknown_cmd_o
);
  logic       cmd_stb, data_stb;
  act_e       act;
  logic [7:0] first_arg, last_arg;

  assign cmd_stb  = byte_valid_i && !dc_sel_i;
  assign data_stb = byte_valid_i && dc_sel_i;

  oled_cmd_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_stb_i(cmd_stb),
    .byte_i   (byte_i),
    .act_o    (act),
    .first_o  (first_arg),
    .last_o   (last_arg),
    .unknown_o(unknown_cmd_o)
  );

  oled_addr_gen #(
    .NUM_COLS(NUM_COLS),
    .NUM_ROWS(NUM_ROWS),
    .VERT_BIT(VERT_BIT)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .first_i    (first_arg),
    .last_i     (last_arg),
    .data_stb_i (data_stb),
    .byte_i     (byte_i),
    .pix_valid_o(pix_valid_o),
    .pix_data_o (pix_data_o),
    .pix_col_o  (pix_col_o),
    .pix_row_o  (pix_row_o),
    .remap_o    (remap_o)
  );
endmodule

// File: rtl/oled_cmd_parser_chk.sv
module oled_cmd_parser_chk #(
  parameter int unsigned NUM_COLS = 64,
  parameter int unsigned NUM_ROWS = 80,
  localparam int unsigned CW = $clog2(NUM_COLS),
  localparam int unsigned RW = $clog2(NUM_ROWS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_valid_i,
  input logic          dc_sel_i,
  input logic [7:0]    byte_i,
  input logic          pix_valid_o,
  input logic [7:0]    pix_data_o,
  input logic [CW-1:0] pix_col_o,
  input logic [RW-1:0] pix_row_o,
  input logic [7:0]    remap_o,
  input logic          unknown_cmd_o
);
  a_r2_pix_from_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(byte_valid_i && dc_sel_i));

  a_r2_pix_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> pix_data_o == $past(byte_i));

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !pix_valid_o && !unknown_cmd_o);

  a_r9_err_from_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unknown_cmd_o |-> $past(byte_valid_i && !dc_sel_i));

  a_r1_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (int'(pix_col_o) < NUM_COLS && int'(pix_row_o) < NUM_ROWS));

  a_r5_remap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_i && !dc_sel_i) |=> $stable(remap_o));
endmodule

bind oled_cmd_parser oled_cmd_parser_chk #(
  .NUM_COLS(NUM_COLS),
  .NUM_ROWS(NUM_ROWS)
) u_chk (.*);

// File: tb/oled_cmd_parser_test.sv
`timescale 1ns/1ps
module oled_cmd_parser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       dc = 1'b0;
  logic [7:0] bdat = '0;
  logic       pix_valid, unk;
  logic [7:0] pix_data, remap;
  logic [5:0] pix_col;
  logic [6:0] pix_row;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  oled_cmd_parser uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .dc_sel_i(dc),
    .byte_i(bdat), .pix_valid_o(pix_valid), .pix_data_o(pix_data),
    .pix_col_o(pix_col), .pix_row_o(pix_row), .remap_o(remap),
    .unknown_cmd_o(unk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b, input bit exp_err, input string req);
    @(negedge clk);
    valid = 1'b1; dc = 1'b0; bdat = b;
    @(negedge clk);
    valid = 1'b0;
    chk(unk == exp_err, req, int'(unk), int'(exp_err));
    chk(!pix_valid, "R2 cmd no write", int'(pix_valid), 0);
  endtask

  task automatic send_data(input logic [7:0] b, input int ec, input int er, input string req);
    @(negedge clk);
    valid = 1'b1; dc = 1'b1; bdat = b;
    @(negedge clk);
    valid = 1'b0;
    chk(pix_valid && !unk, "R2 write strobe", int'(pix_valid), 1);
    chk(pix_data == b, "R2 data", int'(pix_data), int'(b));
    chk(int'(pix_col) == ec, {req, " col"}, int'(pix_col), ec);
    chk(int'(pix_row) == er, {req, " row"}, int'(pix_row), er);
  endtask

  // argument counts and known set taken from R8/R9
  function automatic int exp_nargs(input logic [7:0] op);
    case (op)
      8'h15, 8'h75: return 2;
      8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: return 1;
      8'hB8: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_known(input logic [7:0] op);
    case (op)
      8'h15, 8'h75, 8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF, 8'hB8,
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, 8'hFF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_win(input int cs, input int ce, input int rs, input int re, input bit vert);
    send_cmd(8'hA0, 0, "R5 op");
    send_cmd(vert ? 8'h04 : 8'h00, 0, "R5 arg");
    chk(remap == (vert ? 8'h04 : 8'h00), "R5 remap", int'(remap), vert ? 4 : 0);
    send_cmd(8'h15, 0, "R3 op");
    send_cmd(8'(cs), 0, "R3 arg");
    send_cmd(8'(ce), 0, "R3 arg");
    send_cmd(8'h75, 0, "R4 op");
    send_cmd(8'(rs), 0, "R4 arg");
    send_cmd(8'(re), 0, "R4 arg");
  endtask

  // stepping rules of R6 (horizontal) and R7 (vertical)
  task automatic walk(input int cs, input int ce, input int rs, input int re,
                      input bit vert, input int n);
    int c, r;
    set_win(cs, ce, rs, re, vert);
    c = cs; r = rs;
    for (int i = 0; i < n; i++) begin
      send_data(8'(i + 3), c, r, vert ? "R7 walk" : "R6 walk");
      if (vert) begin
        r++;
        if (r > re) begin r = rs; c++; end
        if (c > ce) c = cs;
      end else begin
        c++;
        if (c > ce) begin c = cs; r++; end
        if (r > re) r = rs;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pix_valid && !unk && remap == 8'h00, "R1 reset outputs", int'(remap), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: full frame sweep from the reset window, then wrap to (0,0)
    for (int k = 0; k <= 64 * 80; k++)
      send_data(8'(k), k % 64, (k / 64) % 80, "R1 frame");

    // R8 R9 R11: every opcode, its argument bytes, then a window probe
    for (int op = 0; op < 256; op++) begin
      int na, c, r, c2, r2;
      bit vert;
      na = exp_nargs(8'(op));
      send_cmd(8'(op), !exp_known(8'(op)), "R9 err flag");
      for (int i = 0; i < na; i++)
        send_cmd(8'h04, 0, "R8 arg consumed");
      vert = (op == 8'hA0);
      chk(remap == (vert ? 8'h04 : 8'h00), "R11 remap", int'(remap), vert ? 4 : 0);
      c = op % 64; r = op % 80;
      send_cmd(8'h15, 0, "R8 probe");
      send_cmd(8'(c), 0, "R8 probe");
      send_cmd(8'd63, 0, "R8 probe");
      send_cmd(8'h75, 0, "R8 probe");
      send_cmd(8'(r), 0, "R8 probe");
      send_cmd(8'd79, 0, "R8 probe");
      send_data(8'(op), c, r, "R8 first write");
      if (vert) begin
        r2 = (r == 79) ? r : r + 1;
        c2 = (r == 79) ? ((c == 63) ? c : c + 1) : c;
      end else begin
        c2 = (c == 63) ? c : c + 1;
        r2 = (c == 63) ? ((r == 79) ? r : r + 1) : r;
      end
      send_data(8'(~op), c2, r2, "R11 second write");
      if (vert) begin
        send_cmd(8'hA0, 0, "R5 restore");
        send_cmd(8'h00, 0, "R5 restore");
      end
    end

    // R6 R7: small windows
    walk(2, 4, 5, 6, 1'b0, 14);
    walk(2, 4, 5, 6, 1'b1, 14);
    walk(60, 63, 77, 79, 1'b1, 13);
    walk(0, 0, 0, 2, 1'b0, 5);

    // R3 R4: modulo on arguments, start above end
    set_win(0, 63, 0, 79, 1'b0);
    send_cmd(8'h15, 0, "R3 mod");
    send_cmd(8'd70, 0, "R3 mod");
    send_cmd(8'd69, 0, "R3 mod");
    send_cmd(8'h75, 0, "R4 mod");
    send_cmd(8'd170, 0, "R4 mod");
    send_cmd(8'd200, 0, "R4 mod");
    send_data(8'h11, 6, 10, "R3 R4 mod first");
    send_data(8'h12, 6, 11, "R3 R4 mod wrap");

    // R10: data in the middle of a column command
    set_win(0, 63, 0, 79, 1'b0);
    send_cmd(8'h15, 0, "R10 op");
    send_cmd(8'd10, 0, "R10 arg");
    send_data(8'hAB, 0, 0, "R10 data while pending");
    send_cmd(8'd20, 0, "R10 last arg");
    send_data(8'hCD, 10, 0, "R10 resumed");
    walk(10, 20, 0, 0, 1'b0, 12);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule